// File: doc/BRIEF.md
# Multichannel Carrier Envelope Demodulator

This block takes one stream of signed 14-bit samples, one per clock, that carries several tones added together, and recovers the amplitude of each tone on its own channel. Every channel has the same three stages, always in this order. A second-order recursive band-pass filter is tuned to that channel's tone. A full-wave rectifier takes the absolute value of the filter output. A first-order exponential averager then smooths the rectified signal into a slowly varying envelope.

The averaged envelopes of all channels are captured together at a programmable decimated rate. They are presented with one shared valid strobe, so a downstream transfer engine can pick them up. Software writes each channel's three filter coefficients through a simple write port. It also sets how many channels are in use, the averaging shift and the decimation factor.

Top module: `fdm_env_demod`

## Requirements
- R1: A synchronous active-high `rst` clears every filter state, all coefficients, the decimation counter, `env_valid` and every envelope word to zero. After reset, all outputs read zero and `env_valid` stays low.
- R2: A write with `cfg_we` high stores `cfg_data` as a signed 18-bit coefficient. The channel is `cfg_addr[ADDR_W-1:2]`, and `cfg_addr[1:0]` selects the coefficient: 0 is the input gain G, 1 is the first feedback term F1, and 2 is the second feedback term F2. Selector 3 stores nothing. A written value is used for samples taken from the next clock edge on.
- R3: The band-pass stage computes acc = G*(x[n]-x[n-2]) + F1*y[n-1] + F2*y[n-2], with coefficients in Q2.16. It then takes y[n] = acc arithmetically shifted right by 16, saturated to the signed 16-bit range [-32768, 32767]. The delayed inputs x[n-1] and x[n-2] are shared by all channels.
- R4: The rectifier outputs |y|, except that an input of -32768 gives 32767.
- R5: The averager updates e = e + ((r - e) >>> K), where r is the rectifier output and the shift is arithmetic. K is taken from `lp_shift`, with values below 4 used as 4 and values above 16 used as 16.
- R6: Each stage is one register. A sample present at edge n updates the band-pass output at edge n. The rectifier takes that output at edge n+1, and the averager takes the rectifier output at edge n+2.
- R7: With D = `decim`, where a value of 0 counts as 1, `env_valid` is high for one cycle every D clocks. On the edge that raises it, every channel's envelope word is loaded from that channel's averager state. Envelope words keep their value while `env_valid` is low.
- R8: After reset is released, the first `env_valid` pulse appears on the D-th rising edge.
- R9: Channels whose index is at or above `active_ch` have their filter and averager state held at zero, so their envelope words read zero from the second strobe after they are switched off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Signed multiplexed input sample, one per clock |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | ADDR_W | Channel index in the upper bits, coefficient selector in bits 1:0 |
| cfg_data | input | COEF_W | Signed Q2.16 coefficient value |
| active_ch | input | CH_W | Number of channels in use (0 to NCH) |
| lp_shift | input | 5 | Averager shift K, clamped to 4..16 |
| decim | input | DEC_W | Decimation factor D, 0 treated as 1 |
| env_valid | output | 1 | One-cycle strobe marking fresh envelope words |
| env_out | output | NCH*BP_W | Envelope words, channel i in bits [i*BP_W +: BP_W] |

## Verification
Seeded random samples driven into randomly tuned stable resonators exercise the full arithmetic chain. They separate correct coefficient routing, shared delay taps and averager rounding from near-misses. A single isolated impulse into a pass-through channel shows the stage latency on its own, so an extra or missing register cannot hide behind filter dynamics. A held negative step into a high-gain channel drives the band-pass output to its negative limit, which shows the difference between a saturating rectifier and a wrapping one. Sweeps of the shift, the decimation factor, including 0, 1 and 255, and the active channel count confirm the clamping, the strobe spacing and the clearing of channels that are switched off.

// File: rtl/fdm_env_demod_pkg.sv
package fdm_env_demod_pkg;
   localparam int unsigned K_MIN = 4;
   localparam int unsigned K_MAX = 16;

   typedef enum logic [1:0] {
      SEL_GAIN = 2'd0,
      SEL_FB1  = 2'd1,
      SEL_FB2  = 2'd2,
      SEL_NONE = 2'd3
   } coef_sel_t;

   function automatic logic [4:0] clamp_shift(input logic [4:0] k);
      if (k < 5'(K_MIN))      return 5'(K_MIN);
      else if (k > 5'(K_MAX)) return 5'(K_MAX);
      else                    return k;
   endfunction
endpackage

// File: rtl/fdm_coef_bank.sv
module fdm_coef_bank
   import fdm_env_demod_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int COEF_W = 18,
   parameter int ADDR_W = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        addr,
   input  logic signed [COEF_W-1:0] data,
   output logic signed [COEF_W-1:0] gain_o [NCH],
   output logic signed [COEF_W-1:0] fb1_o  [NCH],
   output logic signed [COEF_W-1:0] fb2_o  [NCH]
);
   localparam int CHI_W = ADDR_W - 2;

   logic [CHI_W-1:0] wr_ch;
   coef_sel_t        wr_sel;

   assign wr_ch  = addr[ADDR_W-1:2];
   assign wr_sel = coef_sel_t'(addr[1:0]);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk) begin
         if (rst) begin
            gain_o[i] <= '0;
            fb1_o[i]  <= '0;
            fb2_o[i]  <= '0;
         end else if (we && (wr_ch == CHI_W'(i))) begin
            case (wr_sel)
               SEL_GAIN: gain_o[i] <= data;
               SEL_FB1:  fb1_o[i]  <= data;
               SEL_FB2:  fb2_o[i]  <= data;
               default:  ;
            endcase
         end
      end
   end
endmodule

// File: rtl/fdm_bp_resonator.sv
module fdm_bp_resonator #(
   parameter int DATA_W = 14,
   parameter int COEF_W = 18,
   parameter int BP_W   = 16,
   parameter int FRAC   = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     clr,
   input  logic signed [DATA_W-1:0] x_now,
   input  logic signed [DATA_W-1:0] x_old,
   input  logic signed [COEF_W-1:0] gain,
   input  logic signed [COEF_W-1:0] fb1,
   input  logic signed [COEF_W-1:0] fb2,
   output logic signed [BP_W-1:0]   y_out
);
   localparam int ACC_W = COEF_W + BP_W + 2;
   localparam logic signed [ACC_W-1:0] Y_HI = ACC_W'((64'sd1 <<< (BP_W-1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] Y_LO = -Y_HI - ACC_W'(1);

   logic signed [BP_W-1:0]   y1, y2;
   logic signed [DATA_W:0]   dx;
   logic signed [ACC_W-1:0]  p_in, p_f1, p_f2, acc, acc_sh;
   logic signed [BP_W-1:0]   y_new;

   always_comb begin
      dx     = (DATA_W+1)'(x_now) - (DATA_W+1)'(x_old);
      p_in   = ACC_W'(gain) * ACC_W'(dx);
      p_f1   = ACC_W'(fb1)  * ACC_W'(y1);
      p_f2   = ACC_W'(fb2)  * ACC_W'(y2);
      acc    = p_in + p_f1 + p_f2;
      acc_sh = acc >>> FRAC;
      if (acc_sh > Y_HI)      y_new = Y_HI[BP_W-1:0];
      else if (acc_sh < Y_LO) y_new = Y_LO[BP_W-1:0];
      else                    y_new = acc_sh[BP_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         y1 <= '0;
         y2 <= '0;
      end else begin
         y1 <= y_new;
         y2 <= y1;
      end
   end

   assign y_out = y1;
endmodule

// File: rtl/fdm_rectifier.sv
module fdm_rectifier #(
   parameter int BP_W = 16
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   clr,
   input  logic signed [BP_W-1:0] y_in,
   output logic [BP_W-1:0]        r_out
);
   localparam logic signed [BP_W-1:0] NEG_LIM = {1'b1, {(BP_W-1){1'b0}}};
   localparam logic [BP_W-1:0]        POS_LIM = {1'b0, {(BP_W-1){1'b1}}};

   logic [BP_W-1:0] mag;

   always_comb begin
      if (y_in == NEG_LIM)   mag = POS_LIM;
      else if (y_in[BP_W-1]) mag = BP_W'(-y_in);
      else                   mag = BP_W'(y_in);
   end

   always_ff @(posedge clk) begin
      if (rst || clr) r_out <= '0;
      else            r_out <= mag;
   end
endmodule

// File: rtl/fdm_env_average.sv
module fdm_env_average #(
   parameter int BP_W = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            clr,
   input  logic [BP_W-1:0] r_in,
   input  logic [4:0]      k_eff,
   output logic [BP_W-1:0] e_out
);
   logic [BP_W-1:0]      e_q;
   logic signed [BP_W:0] diff, step, e_sum;

   always_comb begin
      diff  = $signed({1'b0, r_in}) - $signed({1'b0, e_q});
      step  = diff >>> k_eff;
      e_sum = $signed({1'b0, e_q}) + step;
   end

   always_ff @(posedge clk) begin
      if (rst || clr) e_q <= '0;
      else            e_q <= e_sum[BP_W-1:0];
   end

   assign e_out = e_q;
endmodule

// File: rtl/fdm_decimator.sv
module fdm_decimator #(
   parameter int DEC_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DEC_W-1:0] decim,
   output logic             take,
   output logic             strobe
);
   logic [DEC_W-1:0] cnt;
   logic [DEC_W-1:0] last;

   assign last = (decim == '0) ? '0 : decim - DEC_W'(1);
   assign take = (cnt >= last);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= take;
         cnt    <= take ? '0 : cnt + DEC_W'(1);
      end
   end
endmodule

// File: rtl/fdm_env_demod.sv
module fdm_env_demod
   import fdm_env_demod_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int DATA_W = 14,
   parameter int COEF_W = 18,
   parameter int BP_W   = DATA_W + 2,
   parameter int DEC_W  = 8,
   localparam int FRAC   = COEF_W - 2,
   localparam int CHI_W  = $clog2(NCH),
   localparam int ADDR_W = CHI_W + 2,
   localparam int CH_W   = $clog2(NCH + 1)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [DATA_W-1:0]     din,
   input  logic                  cfg_we,
   input  logic [ADDR_W-1:0]     cfg_addr,
   input  logic [COEF_W-1:0]     cfg_data,
   input  logic [CH_W-1:0]       active_ch,
   input  logic [4:0]            lp_shift,
   input  logic [DEC_W-1:0]      decim,
   output logic                  env_valid,
   output logic [NCH*BP_W-1:0]   env_out
);
   initial begin
      assert (NCH >= 2) else $error("NCH must be at least 2");
      assert (BP_W > DATA_W) else $error("BP_W must exceed DATA_W");
      assert (COEF_W >= 4) else $error("COEF_W too small");
      assert (DEC_W >= 1) else $error("DEC_W must be positive");
   end

   logic signed [DATA_W-1:0] x_now, x_d1, x_d2;
   logic signed [COEF_W-1:0] gain_c [NCH];
   logic signed [COEF_W-1:0] fb1_c  [NCH];
   logic signed [COEF_W-1:0] fb2_c  [NCH];
   logic [4:0]               k_eff;
   logic                     take;

   assign x_now = $signed(din);
   assign k_eff = clamp_shift(lp_shift);

   always_ff @(posedge clk) begin
      if (rst) begin
         x_d1 <= '0;
         x_d2 <= '0;
      end else begin
         x_d1 <= x_now;
         x_d2 <= x_d1;
      end
   end

   fdm_coef_bank #(.NCH(NCH), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) coef_i (
      .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .data($signed(cfg_data)),
      .gain_o(gain_c), .fb1_o(fb1_c), .fb2_o(fb2_c)
   );

   fdm_decimator #(.DEC_W(DEC_W)) dec_i (
      .clk(clk), .rst(rst), .decim(decim), .take(take), .strobe(env_valid)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      logic                   off;
      logic signed [BP_W-1:0] y_bp;
      logic [BP_W-1:0]        r_abs;
      logic [BP_W-1:0]        e_avg;
      logic [BP_W-1:0]        env_q;

      assign off = (CH_W'(i) >= active_ch);

      fdm_bp_resonator #(.DATA_W(DATA_W), .COEF_W(COEF_W), .BP_W(BP_W), .FRAC(FRAC)) bp_i (
         .clk(clk), .rst(rst), .clr(off), .x_now(x_now), .x_old(x_d2),
         .gain(gain_c[i]), .fb1(fb1_c[i]), .fb2(fb2_c[i]), .y_out(y_bp)
      );

      fdm_rectifier #(.BP_W(BP_W)) rect_i (
         .clk(clk), .rst(rst), .clr(off), .y_in(y_bp), .r_out(r_abs)
      );

      fdm_env_average #(.BP_W(BP_W)) avg_i (
         .clk(clk), .rst(rst), .clr(off), .r_in(r_abs), .k_eff(k_eff), .e_out(e_avg)
      );

      always_ff @(posedge clk) begin
         if (rst)       env_q <= '0;
         else if (take) env_q <= e_avg;
      end

      assign env_out[i*BP_W +: BP_W] = env_q;
   end
endmodule

// File: rtl/fdm_env_demod_chk.sv
module fdm_env_demod_chk #(
   parameter int NCH   = 4,
   parameter int BP_W  = 16,
   parameter int CH_W  = 3,
   parameter int DEC_W = 8
) (
   input logic                clk,
   input logic                rst,
   input logic [CH_W-1:0]     active_ch,
   input logic [DEC_W-1:0]    decim,
   input logic                env_valid,
   input logic [NCH*BP_W-1:0] env_out
);
   // R7: a strobe is never followed by another when the factor exceeds one
   assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
      (env_valid && (decim > DEC_W'(1))) |=> !env_valid);

   // R7: envelope words change only together with the strobe
   assert_hold_between_R7: assert property (@(posedge clk) disable iff (rst)
      (!env_valid && !$past(rst)) |-> $stable(env_out));

   for (genvar i = 0; i < NCH; i++) begin : g_c
      // R4: rectified and averaged values never reach the sign bit
      assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
         env_out[i*BP_W + BP_W - 1] == 1'b0);

      // R9: a channel switched off reports a zero envelope
      assert_off_zero_R9: assert property (@(posedge clk) disable iff (rst)
         (env_valid && ($past(active_ch, 2) <= CH_W'(i))) |-> (env_out[i*BP_W +: BP_W] == '0));
   end
endmodule

bind fdm_env_demod fdm_env_demod_chk #(.NCH(NCH), .BP_W(BP_W), .CH_W(CH_W), .DEC_W(DEC_W)) chk_i (
   .clk(clk), .rst(rst), .active_ch(active_ch), .decim(decim),
   .env_valid(env_valid), .env_out(env_out)
);

// File: tb/fdm_env_demod_tb_top.sv
`timescale 1ns/1ps
module fdm_env_demod_tb_top;
   localparam int NCH    = 4;
   localparam int DATA_W = 14;
   localparam int COEF_W = 18;
   localparam int BP_W   = 16;
   localparam int DEC_W  = 8;
   localparam int ADDR_W = 4;
   localparam int CH_W   = 3;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic [DATA_W-1:0]   din = '0;
   logic                cfg_we = 1'b0;
   logic [ADDR_W-1:0]   cfg_addr = '0;
   logic [COEF_W-1:0]   cfg_data = '0;
   logic [CH_W-1:0]     active_ch = CH_W'(NCH);
   logic [4:0]          lp_shift = 5'd6;
   logic [DEC_W-1:0]    decim = 8'd5;
   logic                env_valid;
   logic [NCH*BP_W-1:0] env_out;

   always #4 clk = ~clk;

   fdm_env_demod #(.NCH(NCH), .DATA_W(DATA_W), .COEF_W(COEF_W), .BP_W(BP_W), .DEC_W(DEC_W)) dut_i (
      .clk(clk), .rst(rst), .din(din), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .active_ch(active_ch), .lp_shift(lp_shift), .decim(decim),
      .env_valid(env_valid), .env_out(env_out)
   );

   int    checks = 0;
   int    failures = 0;
   bit    finished = 0;
   int    cyc = 0;
   string cur_req = "R1";

   // reference state, built from the requirement formulas
   longint m_x1, m_x2;
   longint m_g [NCH], m_f1 [NCH], m_f2 [NCH];
   longint m_y1 [NCH], m_y2 [NCH], m_r [NCH], m_e [NCH], m_env [NCH];
   longint m_cnt;
   bit     m_valid;

   function automatic longint sat16(input longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic longint kclamp(input longint k);
      if (k < 4)  return 4;
      if (k > 16) return 16;
      return k;
   endfunction

   task automatic model_step();
      longint xn, eff, k, acc;
      longint ny [NCH], nr [NCH], ne [NCH];
      xn = longint'($signed(din));
      if (rst) begin
         m_x1 = 0; m_x2 = 0; m_cnt = 0; m_valid = 0;
         for (int i = 0; i < NCH; i++) begin
            m_g[i] = 0; m_f1[i] = 0; m_f2[i] = 0;
            m_y1[i] = 0; m_y2[i] = 0; m_r[i] = 0; m_e[i] = 0; m_env[i] = 0;
         end
         return;
      end
      k = kclamp(longint'(lp_shift));
      for (int i = 0; i < NCH; i++) begin
         acc   = m_g[i] * (xn - m_x2) + m_f1[i] * m_y1[i] + m_f2[i] * m_y2[i];
         ny[i] = sat16(acc >>> 16);
         nr[i] = (m_y1[i] == -32768) ? 32767 : ((m_y1[i] < 0) ? -m_y1[i] : m_y1[i]);
         ne[i] = m_e[i] + ((m_r[i] - m_e[i]) >>> k);
      end
      eff = (decim == 0) ? 1 : longint'(decim);
      if (m_cnt >= eff - 1) begin
         for (int i = 0; i < NCH; i++) m_env[i] = m_e[i];
         m_cnt = 0; m_valid = 1;
      end else begin
         m_cnt = m_cnt + 1; m_valid = 0;
      end
      for (int i = 0; i < NCH; i++) begin
         if (i >= int'(active_ch)) begin
            m_y2[i] = 0; m_y1[i] = 0; m_r[i] = 0; m_e[i] = 0;
         end else begin
            m_y2[i] = m_y1[i]; m_y1[i] = ny[i]; m_r[i] = nr[i]; m_e[i] = ne[i];
         end
      end
      m_x2 = m_x1; m_x1 = xn;
      if (cfg_we && cfg_addr[3:2] < NCH) begin
         case (cfg_addr[1:0])
            2'd0: m_g[cfg_addr[3:2]]  = longint'($signed(cfg_data));
            2'd1: m_f1[cfg_addr[3:2]] = longint'($signed(cfg_data));
            2'd2: m_f2[cfg_addr[3:2]] = longint'($signed(cfg_data));
            default: ;
         endcase
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", req, what, cyc, act, exp);
      end
   endtask

   task automatic compare_all();
      check(env_valid == m_valid, cur_req, "env_valid", longint'(env_valid), longint'(m_valid));
      for (int i = 0; i < NCH; i++)
         check(longint'(env_out[i*BP_W +: BP_W]) == m_env[i], cur_req, $sformatf("env ch%0d", i),
               longint'(env_out[i*BP_W +: BP_W]), m_env[i]);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      cyc++;
      model_step();
      compare_all();
   endtask

   task automatic wr(input int ch, input int sel, input longint val);
      cfg_we = 1'b1;
      cfg_addr = ADDR_W'({ch[1:0], sel[1:0]});
      cfg_data = COEF_W'(val);
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic run_random(input int n);
      for (int c = 0; c < n; c++) begin
         din = DATA_W'($urandom);
         tick();
      end
   endtask

   function automatic longint envw(input int i);
      return longint'(env_out[i*BP_W +: BP_W]);
   endfunction

   initial begin
      #1_200_000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired cycle=%0d actual=0 expected=1", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int first;
      void'($urandom(32'd20240611));
      #1;
      // R1: reset state
      cur_req = "R1";
      for (int c = 0; c < 3; c++) tick();
      check(env_valid == 1'b0, "R1", "valid in reset", longint'(env_valid), 0);
      check(env_out == '0, "R1", "env in reset", longint'(env_out[BP_W-1:0]), 0);

      // R8: first strobe on the D-th edge after release
      cur_req = "R8";
      rst = 1'b0;
      decim = 8'd5;
      first = 0;
      for (int c = 1; c <= 8; c++) begin
         tick();
         if (env_valid && first == 0) first = c;
      end
      check(first == 5, "R8", "first strobe edge", first, 5);

      // R2: coefficient programming, selector 3 stores nothing
      cur_req = "R2";
      for (int ch = 0; ch < NCH; ch++) begin
         wr(ch, 0, longint'($urandom_range(4000, 500)));
         wr(ch, 1, longint'($urandom_range(236000, 0)) - 118000);
         wr(ch, 2, -(58000 + longint'($urandom_range(5000, 0))));
         wr(ch, 3, 131071);
      end
      run_random(200);

      // R3: random stimulus through all channels
      cur_req = "R3";
      lp_shift = 5'd6;
      decim = 8'd7;
      run_random(3000);

      // R6: isolated impulse through a pass-through channel
      cur_req = "R6";
      wr(0, 0, 65536); wr(0, 1, 0); wr(0, 2, 0);
      lp_shift = 5'd4; decim = 8'd1;
      din = '0;
      for (int c = 0; c < 10; c++) tick();
      din = DATA_W'(4000);
      tick();
      din = '0;
      for (int c = 0; c < 20; c++) tick();

      // R4: drive channel 0 into negative saturation
      cur_req = "R4";
      wr(0, 0, 131071); wr(0, 1, 131071); wr(0, 2, 0);
      din = DATA_W'(-8192);
      for (int c = 0; c < 400; c++) tick();
      check(envw(0) >= 32752 && envw(0) <= 32767, "R4", "saturated envelope", envw(0), 32767);

      // R5: shift clamping
      cur_req = "R5";
      wr(0, 0, 3000); wr(0, 1, 60000); wr(0, 2, -62000);
      lp_shift = 5'd0;
      run_random(1000);
      lp_shift = 5'd31;
      run_random(1000);
      lp_shift = 5'd9;
      run_random(500);

      // R7: decimation factors
      cur_req = "R7";
      decim = 8'd0;
      for (int c = 0; c < 50; c++) begin
         din = DATA_W'($urandom);
         tick();
         check(env_valid == 1'b1, "R7", "decim 0 strobe", longint'(env_valid), 1);
      end
      decim = 8'd1; run_random(50);
      decim = 8'd3; run_random(100);
      decim = 8'd255; run_random(600);

      // R9: fewer active channels
      cur_req = "R9";
      decim = 8'd4;
      active_ch = 3'd2;
      run_random(500);
      check(envw(2) == 0 && envw(3) == 0, "R9", "off channels zero", envw(2) + envw(3), 0);
      active_ch = 3'd0;
      run_random(100);
      check(env_out == '0, "R9", "all off zero", envw(0), 0);
      active_ch = 3'd4;
      run_random(300);

      // R1: reset in mid-run
      cur_req = "R1";
      rst = 1'b1;
      tick(); tick();
      check(env_out == '0 && !env_valid, "R1", "mid-run reset", envw(0), 0);
      rst = 1'b0;
      run_random(50);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule